// File: doc/BRIEF.md
# Shadow-Compare Trap Generator

This block sits around a group of suspect signal paths inside a pipeline. Each monitored path is described by a pair. The first value of a pair is a source value taken from before the suspect logic. The second is a backup value: what the original, unmodified logic would have put on the sink. The block drives each visible sink from its paired source, passed through that pair's fixed number of delay registers. Logic downstream therefore never sees anything the suspect logic computed.

Every cycle, the backup of every pair is compared with that pair's delayed source, and all comparisons run in parallel. Any difference is an event. The differences are ORed into a single trap request, and a pipeline flush is raised with it so that no modified state commits. The request can be withheld while interrupts are disabled. It stays pending until the exception stage acknowledges it. A sticky per-pair hit vector tells the handler which pairs fired, and software clears it bit by bit.

Several pairs may map to one sink. The lowest-indexed pair mapped to a sink drives it, but every pair on that sink is still compared. Pair delays and the pair-to-sink map are 4-bit fields per pair, packed in parameter vectors with pair i at bits [4i+3:4i].

Top module: `shadow_trap_gen`

## Requirements
- R1: Each sink equals the source of its driving pair delayed by that pair's delay depth D in clock cycles. With D = 0 the sink follows the source in the same cycle.
- R2: Delay registers reset to zero, so during reset and for the first D cycles after reset a sink driven through D > 0 registers reads zero.
- R3: A pair with delay D > 0 is not compared during the first D cycles after reset, so a differing backup in that window raises no trap and sets no hit bit.
- R4: A pair mismatches when it is compared and its backup differs from its delayed source. Hit bit i of `hit_o` belongs to pair i and is set on the clock edge that ends a cycle in which pair i mismatched.
- R5: While `irq_en_i` is high, `trap_req_o` and `flush_o` are high in the same cycle as any mismatch. They are also high whenever an event is pending.
- R6: While `irq_en_i` is low, `trap_req_o` and `flush_o` are low. An event seen in that time stays pending and is presented once `irq_en_i` returns high.
- R7: A pending event is held until `trap_ack_i`. An acknowledge clears the pending state on its clock edge, and this takes priority over a mismatch seen in the same cycle, so one trap is taken per event.
- R8: Hit bits hold until the matching bit of `hit_clr_i` is high at a clock edge. A new mismatch on the same edge wins over the clear.
- R9: Where several pairs share a sink, the lowest-indexed pair drives it, and a mismatch on any other pair of that sink still raises a trap and sets its own hit bit.
- R10: When every compared backup equals its delayed source and nothing is pending, no trap is raised and no hit bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_PAIRS*DATA_W | Source value per pair, pair i at slice i |
| bak_i | input | NUM_PAIRS*DATA_W | Backup value per pair from the original logic |
| irq_en_i | input | 1 | Interrupts enabled; low withholds the trap |
| trap_ack_i | input | 1 | Exception stage has taken the trap |
| hit_clr_i | input | NUM_PAIRS | Software clear mask for the hit vector |
| sink_o | output | NUM_SINKS*DATA_W | Visible sink values, sink s at slice s |
| trap_req_o | output | 1 | Trap request to the exception stage |
| flush_o | output | 1 | Pipeline flush request, raised with the trap |
| hit_o | output | NUM_PAIRS | Sticky record of pairs that mismatched |

## Verification
The bench builds the block with four pairs of 8 bits on three sinks. The pair delays are 0, 1, 2 and 1, and pairs 1 and 2 both map to sink 1. With these values one build covers a combinational pass-through, single-stage and two-stage delays with their fill masking, and a shared sink whose non-driving pair must still trap. Directed cycles hit the fill window, withheld traps, an acknowledge that coincides with a mismatch, and a clear that coincides with a set. Random traffic then mixes sources, corrupted backups, interrupt enable, acknowledge and clear against a bench model.

// File: rtl/stg_pkg.sv
package stg_pkg;
  localparam int unsigned CFG_W     = 4;
  localparam int unsigned MAX_PAIRS = 16;
  typedef logic [MAX_PAIRS*CFG_W-1:0] cfg_vec_t;

  function automatic int cfg_at(cfg_vec_t v, int i);
    logic [CFG_W-1:0] f;
    f = v[i*CFG_W +: CFG_W];
    return int'(f);
  endfunction

  // lowest pair mapped to sink s, -1 when none
  function automatic int first_driver(cfg_vec_t map, int n, int s);
    int r;
    r = -1;
    for (int i = 0; i < n; i++)
      if (r < 0 && cfg_at(map, i) == s) r = i;
    return r;
  endfunction
endpackage

// File: rtl/stg_delay_line.sv
module stg_delay_line #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o,
  output logic              valid_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] stage_q [DEPTH];
  logic [CNT_W-1:0]  fill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < int'(DEPTH); i++) stage_q[i] <= stage_q[i-1];
    end
  end

  // saturating fill count masks compares until the line holds real data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        fill_q <= '0;
    else if (fill_q != CNT_W'(DEPTH))   fill_q <= fill_q + 1'b1;
  end

  assign q_o     = stage_q[DEPTH-1];
  assign valid_o = (fill_q == CNT_W'(DEPTH));
endmodule

// File: rtl/stg_pair_check.sv
module stg_pair_check #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] dly_i,
  input  logic [DATA_W-1:0] bak_i,
  input  logic              valid_i,
  output logic              mism_o
);
  assign mism_o = valid_i && (dly_i != bak_i);
endmodule

// File: rtl/stg_trap_ctrl.sv
module stg_trap_ctrl #(
  parameter int unsigned NUM_PAIRS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_PAIRS-1:0] mism_i,
  input  logic                 irq_en_i,
  input  logic                 trap_ack_i,
  input  logic [NUM_PAIRS-1:0] hit_clr_i,
  output logic                 any_o,
  output logic                 trap_req_o,
  output logic                 flush_o,
  output logic [NUM_PAIRS-1:0] hit_o
);
  logic                 pend_q;
  logic [NUM_PAIRS-1:0] hit_q;

  assign any_o = |mism_i;

  // ack wins over a same-cycle event: one trap per event
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pend_q <= 1'b0;
    else if (trap_ack_i) pend_q <= 1'b0;
    else if (any_o)      pend_q <= 1'b1;
  end

  // set wins over clear so no event is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hit_q <= '0;
    else         hit_q <= (hit_q & ~hit_clr_i) | mism_i;
  end

  assign trap_req_o = irq_en_i & (pend_q | any_o);
  assign flush_o    = trap_req_o;
  assign hit_o      = hit_q;
endmodule

// File: rtl/shadow_trap_gen.sv
module shadow_trap_gen
  import stg_pkg::*;
#(
  parameter int unsigned NUM_PAIRS = 4,
  parameter int unsigned NUM_SINKS = 3,
  parameter int unsigned DATA_W    = 8,
  parameter cfg_vec_t    PAIR_DLY  = cfg_vec_t'(64'h1210),
  parameter cfg_vec_t    PAIR_SINK = cfg_vec_t'(64'h2110)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_PAIRS*DATA_W-1:0] src_i,
  input  logic [NUM_PAIRS*DATA_W-1:0] bak_i,
  input  logic                        irq_en_i,
  input  logic                        trap_ack_i,
  input  logic [NUM_PAIRS-1:0]        hit_clr_i,
  output logic [NUM_SINKS*DATA_W-1:0] sink_o,
  output logic                        trap_req_o,
  output logic                        flush_o,
  output logic [NUM_PAIRS-1:0]        hit_o
);
  logic [DATA_W-1:0]    dly [NUM_PAIRS];
  logic [NUM_PAIRS-1:0] vld;
  logic [NUM_PAIRS-1:0] mism;
  logic                 mism_any;

  for (genvar p = 0; p < int'(NUM_PAIRS); p++) begin : g_pair
    localparam int unsigned D = unsigned'(cfg_at(PAIR_DLY, p));
    if (D == 0) begin : g_pass
      assign dly[p] = src_i[p*DATA_W +: DATA_W];
      assign vld[p] = 1'b1;
    end else begin : g_dly
      stg_delay_line #(.DATA_W(DATA_W), .DEPTH(D)) u_dly (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .d_i     (src_i[p*DATA_W +: DATA_W]),
        .q_o     (dly[p]),
        .valid_o (vld[p])
      );
    end
    stg_pair_check #(.DATA_W(DATA_W)) u_chk (
      .dly_i   (dly[p]),
      .bak_i   (bak_i[p*DATA_W +: DATA_W]),
      .valid_i (vld[p]),
      .mism_o  (mism[p])
    );
  end

  for (genvar s = 0; s < int'(NUM_SINKS); s++) begin : g_sink
    localparam int DRV = first_driver(PAIR_SINK, int'(NUM_PAIRS), s);
    if (DRV < 0) begin : g_none
      assign sink_o[s*DATA_W +: DATA_W] = '0;
    end else begin : g_drv
      assign sink_o[s*DATA_W +: DATA_W] = dly[DRV];
    end
  end

  stg_trap_ctrl #(.NUM_PAIRS(NUM_PAIRS)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mism_i     (mism),
    .irq_en_i   (irq_en_i),
    .trap_ack_i (trap_ack_i),
    .hit_clr_i  (hit_clr_i),
    .any_o      (mism_any),
    .trap_req_o (trap_req_o),
    .flush_o    (flush_o),
    .hit_o      (hit_o)
  );
endmodule

// File: rtl/stg_checker.sv
module stg_checker #(
  parameter int unsigned NUM_PAIRS = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 irq_en_i,
  input logic                 trap_ack_i,
  input logic [NUM_PAIRS-1:0] hit_clr_i,
  input logic                 trap_req_o,
  input logic [NUM_PAIRS-1:0] hit_o,
  input logic [NUM_PAIRS-1:0] mism,
  input logic                 mism_any
);
  p_withheld_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |-> !trap_req_o);

  p_same_cycle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mism_any && irq_en_i) |-> trap_req_o);

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_req_o && !trap_ack_i) |=> (trap_req_o || !irq_en_i));

  p_ack_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_ack_i |=> (trap_req_o == (irq_en_i && mism_any)));

  p_hit_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mism != '0) |=> ((hit_o & $past(mism)) == $past(mism)));

  p_hit_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((hit_o & ~hit_clr_i) != '0) |=>
      ((hit_o & $past(hit_o & ~hit_clr_i)) == $past(hit_o & ~hit_clr_i)));
endmodule

bind shadow_trap_gen stg_checker #(.NUM_PAIRS(NUM_PAIRS)) u_stg_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .irq_en_i   (irq_en_i),
  .trap_ack_i (trap_ack_i),
  .hit_clr_i  (hit_clr_i),
  .trap_req_o (trap_req_o),
  .hit_o      (hit_o),
  .mism       (mism),
  .mism_any   (mism_any)
);

// File: tb/shadow_trap_gen_tb.sv
`timescale 1ns/1ps
module shadow_trap_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic [31:0] bak = '0;
  logic        irq = 1'b0;
  logic        ack = 1'b0;
  logic [3:0]  clr = '0;
  logic [23:0] sink;
  logic        trap, flush;
  logic [3:0]  hit;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model state
  logic [31:0] src_log [16];
  int          cyc = 0;
  bit          pend_m = 1'b0;
  logic [3:0]  hit_m = '0;

  always #5 clk = ~clk;

  shadow_trap_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .bak_i(bak),
    .irq_en_i(irq), .trap_ack_i(ack), .hit_clr_i(clr),
    .sink_o(sink), .trap_req_o(trap), .flush_o(flush), .hit_o(hit)
  );

  function automatic int dly_of(int p);
    case (p)
      0: return 0;
      1: return 1;
      2: return 2;
      default: return 1;
    endcase
  endfunction

  function automatic int drv_of(int s);
    case (s)
      0: return 0;
      1: return 1;
      default: return 3;
    endcase
  endfunction

  function automatic logic [7:0] dly_exp(int p);
    int d = dly_of(p);
    logic [31:0] v;
    if (d == 0) return src_log[cyc % 16][p*8 +: 8];
    if (cyc < d) return 8'h00;
    v = src_log[(cyc - d) % 16];
    return v[p*8 +: 8];
  endfunction

  function automatic logic [3:0] mism_exp();
    logic [3:0] m;
    for (int p = 0; p < 4; p++)
      m[p] = (cyc >= dly_of(p)) && (bak[p*8 +: 8] != dly_exp(p));
    return m;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // starts and ends at a negedge; cmask corrupts those pairs' backups
  task automatic step(logic [31:0] s, logic [3:0] cmask, bit i_en, bit a,
                      logic [3:0] c, string tag);
    logic [31:0] b;
    logic [3:0]  m;
    bit          t_exp;
    src = s;
    src_log[cyc % 16] = s;
    for (int p = 0; p < 4; p++)
      b[p*8 +: 8] = dly_exp(p) ^ (cmask[p] ? 8'h5A : 8'h00);
    bak = b; irq = i_en; ack = a; clr = c;
    #2;
    m = mism_exp();
    for (int k = 0; k < 3; k++) begin
      int d = dly_of(drv_of(k));
      chk(sink[k*8 +: 8] == dly_exp(drv_of(k)),
          (cyc < d) ? "R2" : ((k == 1) ? "R9" : "R1"), "sink",
          int'(sink[k*8 +: 8]), int'(dly_exp(drv_of(k))));
    end
    t_exp = i_en && (pend_m || (m != 0));
    chk(trap == t_exp, i_en ? tag : "R6", "trap_req", int'(trap), int'(t_exp));
    chk(flush == t_exp, i_en ? tag : "R6", "flush", int'(flush), int'(t_exp));
    chk(hit == hit_m, tag, "hit", int'(hit), int'(hit_m));
    @(posedge clk);
    pend_m = a ? 1'b0 : (pend_m | (m != 0));
    hit_m  = (hit_m & ~c) | m;
    cyc++;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) src_log[i] = '0;
    repeat (3) @(negedge clk);
    // reset state: R2
    chk(hit == 4'h0, "R2", "hit in reset", int'(hit), 0);
    chk(trap == 1'b0, "R2", "trap in reset", int'(trap), 0);
    chk(sink[23:8] == 16'h0, "R2", "delayed sinks in reset", int'(sink[23:8]), 0);
    rst_n = 1'b1;

    // R3: corrupt pairs still inside their fill window
    step(32'hA1B2C3D4, 4'b1110, 1'b1, 1'b0, 4'h0, "R3");
    step(32'h11223344, 4'b0100, 1'b1, 1'b0, 4'h0, "R3");
    // R10: clean traffic
    for (int i = 0; i < 4; i++) step($urandom, 4'h0, 1'b1, 1'b0, 4'h0, "R10");
    // R6: event withheld, then presented
    step($urandom, 4'b0001, 1'b0, 1'b0, 4'h0, "R6");
    step($urandom, 4'h0, 1'b0, 1'b0, 4'h0, "R6");
    step($urandom, 4'h0, 1'b1, 1'b0, 4'h0, "R6");
    // R7: held until ack, then gone; R4 hit visible
    step($urandom, 4'h0, 1'b1, 1'b0, 4'h0, "R7");
    step($urandom, 4'h0, 1'b1, 1'b1, 4'h0, "R7");
    step($urandom, 4'h0, 1'b1, 1'b0, 4'h0, "R4");
    // R8: clear bit 0, then set and clear bit 3 together
    step($urandom, 4'h0, 1'b1, 1'b0, 4'b0001, "R8");
    step($urandom, 4'b1000, 1'b1, 1'b1, 4'b1000, "R8");
    step($urandom, 4'h0, 1'b1, 1'b0, 4'h0, "R8");
    // R7: mismatch coinciding with ack leaves nothing pending
    step($urandom, 4'b0001, 1'b1, 1'b1, 4'hF, "R7");
    step($urandom, 4'h0, 1'b1, 1'b0, 4'h0, "R7");
    // R9: non-driving pair of the shared sink
    step($urandom, 4'b0100, 1'b1, 1'b1, 4'h0, "R9");
    step($urandom, 4'h0, 1'b1, 1'b0, 4'h0, "R9");
    // random mix
    for (int i = 0; i < 2000; i++) begin
      logic [3:0] cm;
      cm = (($urandom % 8) == 0) ? 4'($urandom) : 4'h0;
      step($urandom, cm, ($urandom % 4) != 0, ($urandom % 4) == 0,
           (($urandom % 8) == 0) ? 4'($urandom) : 4'h0, "R5");
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule